// File: doc/BRIEF.md
# Ratio-Based Controlled Clock Generator

This block produces a set of controlled clocks from one free-running uncontrolled clock (`uclk`) and a global run enable. Every controlled clock is described by an integer divisor against an implicit fastest clock, a duty mode and a phase offset. One fastest-clock cycle is one uncontrolled cycle in which `run_en` is high. All outputs are registered on rising edges of `uclk`, so every controlled edge falls on a rising edge of the uncontrolled clock.

A lane whose duty cycle does not matter gives a one-cycle strobe at each of its rising edges. A lane with a defined duty cycle gives a level waveform that holds while the enable is low. The fastest clock always exists and is exposed as `fast_strobe`, even when no lane is set to divisor 1. A cycle stamp counts fastest-clock cycles since reset. Configuration inputs are sampled while reset is high and must stay constant until the next reset.

Top module: `ratio_clock_gen`

## Requirements
- R1: `rst` is synchronous and active high. While `rst` is sampled high, every `cclk` bit, `fast_strobe` and `cycle_stamp` are zero after the next `uclk` rising edge.
- R2: After each rising edge where `run_en` is high, `cycle_stamp` is one greater than before. After an edge where `run_en` is low, it keeps its value.
- R3: `cycle_stamp` is STAMP_W bits wide (64 by default). After its all-ones value it wraps to zero, with no other indication.
- R4: `fast_strobe` is high in the cycle after an edge where `run_en` was high, and low in the cycle after an edge where it was low.
- R5: Let k count enabled cycles from 0, starting at the first enabled cycle after reset. Lane i uses `div_cfg[8i+7:8i]` as N, `phase_cfg[8i+7:8i]` as P and `duty_cfg[i]` as its mode (0 = duty don't-care, 1 = defined duty). In don't-care mode, `cclk[i]` is high after enabled cycle k exactly when k >= P and (k-P) mod N == 0. It is low after every other edge, including every edge where `run_en` is low.
- R6: In defined-duty mode with N >= 2, `cclk[i]` after enabled cycle k >= P equals ((k-P) mod N) < floor(N/2). It is high for floor(N/2) fastest cycles and low for the remaining cycles of each period.
- R7: In defined-duty mode with N = 1, the lane alternates high and low on successive enabled cycles. Its period is two uncontrolled edges, because the rise and the fall each need their own edge.
- R8: In defined-duty mode, an edge where `run_en` is low leaves `cclk[i]` unchanged and does not advance the lane's position.
- R9: The phase offset P keeps `cclk[i]` low for the first P enabled cycles after reset, in either mode.
- R10: A divisor value of 0 behaves exactly like a divisor of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| uclk | input | 1 | Free-running uncontrolled clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Global enable; low stalls all lanes and the stamp |
| div_cfg | input | NUM_CLKS*RATIO_W | Per-lane divisor N, lane i at bits [RATIO_W*i +: RATIO_W] |
| phase_cfg | input | NUM_CLKS*RATIO_W | Per-lane phase offset P in fastest cycles |
| duty_cfg | input | NUM_CLKS | Per-lane mode: 0 don't-care, 1 defined duty |
| cclk | output | NUM_CLKS | Controlled clock outputs |
| fast_strobe | output | 1 | Fastest 1/1 clock as a per-cycle strobe |
| cycle_stamp | output | STAMP_W | Fastest-clock cycles since reset |

## Verification
Assertions check on every cycle the properties that follow from one edge to the next. These are the clearing by reset, the stamp stepping by one or holding (including wrap from all ones), the fast strobe following the enable, don't-care lanes staying low after disabled cycles, defined-duty lanes holding while stalled, and lanes staying quiet during their phase delay. Some behaviours depend on the whole enabled-cycle history and are shown only by the bench's model: the exact place of each edge within a period, the floor(N/2) high time, the half-rate waveform of a defined-duty divisor-1 lane, and a divisor of 0 acting as 1. The bench checks these under random enable patterns and several lane configurations.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
    parameter int unsigned RCG_RATIO_W = 8;
    parameter int unsigned RCG_STAMP_W = 64;

    typedef enum logic {
        DUTY_DONT_CARE = 1'b0,
        DUTY_DEFINED   = 1'b1
    } duty_mode_e;
endpackage

// File: rtl/rcg_lane.sv
module rcg_lane
    import rcg_pkg::*;
#(
    parameter int unsigned RATIO_W = RCG_RATIO_W
) (
    input  logic               uclk,
    input  logic               rst,
    input  logic               run_en,
    input  logic [RATIO_W-1:0] div_n,
    input  logic [RATIO_W-1:0] phase_n,
    input  logic               duty_mode,
    output logic               lane_out
);
    typedef struct packed {
        logic [RATIO_W-1:0] dly;
        logic [RATIO_W-1:0] pos;
        logic               out;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic [RATIO_W-1:0] eff_n;
    logic [RATIO_W-1:0] hi_len;
    duty_mode_e         mode;

    always_comb begin
        mode = duty_mode_e'(duty_mode);
        // a zero divisor acts as one; a defined-duty 1/1 needs two edges
        if (div_n <= RATIO_W'(1)) begin
            eff_n = (mode == DUTY_DEFINED) ? RATIO_W'(2) : RATIO_W'(1);
        end else begin
            eff_n = div_n;
        end
        hi_len = eff_n >> 1;
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.dly = phase_n;
            st_d.pos = '0;
            st_d.out = 1'b0;
        end else if (run_en) begin
            if (st_q.dly != '0) begin
                st_d.dly = st_q.dly - RATIO_W'(1);
                st_d.out = 1'b0;
            end else begin
                if (mode == DUTY_DEFINED) begin
                    st_d.out = (st_q.pos < hi_len);
                end else begin
                    st_d.out = (st_q.pos == '0);
                end
                st_d.pos = (st_q.pos >= eff_n - RATIO_W'(1)) ? '0 : st_q.pos + RATIO_W'(1);
            end
        end else if (mode == DUTY_DONT_CARE) begin
            st_d.out = 1'b0;
        end
    end

    always_ff @(posedge uclk) begin
        st_q <= st_d;
    end

    assign lane_out = st_q.out;

    AST_LANE_RESET: assert property (@(posedge uclk) rst |=> !lane_out); // R1
    AST_DC_IDLE: assert property (@(posedge uclk) disable iff (rst)
        (!duty_mode && !run_en) |=> !lane_out); // R5
    AST_DUTY_HOLD: assert property (@(posedge uclk) disable iff (rst)
        (duty_mode && !run_en) |=> $stable(lane_out)); // R8
    AST_PHASE_QUIET: assert property (@(posedge uclk) disable iff (rst)
        (st_q.dly != '0) |=> !lane_out); // R9
endmodule

// File: rtl/rcg_stamp.sv
module rcg_stamp
    import rcg_pkg::*;
#(
    parameter int unsigned STAMP_W = RCG_STAMP_W
) (
    input  logic               uclk,
    input  logic               rst,
    input  logic               run_en,
    output logic [STAMP_W-1:0] stamp
);
    typedef struct packed {
        logic [STAMP_W-1:0] cnt;
    } stamp_st_t;

    stamp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt = '0;
        end else if (run_en) begin
            st_d.cnt = st_q.cnt + STAMP_W'(1);
        end
    end

    always_ff @(posedge uclk) begin
        st_q <= st_d;
    end

    assign stamp = st_q.cnt;

    AST_STAMP_RESET: assert property (@(posedge uclk) rst |=> (stamp == '0)); // R1
    AST_STAMP_STEP: assert property (@(posedge uclk) disable iff (rst)
        run_en |=> (stamp == $past(stamp) + STAMP_W'(1))); // R2
    AST_STAMP_HOLD: assert property (@(posedge uclk) disable iff (rst)
        !run_en |=> $stable(stamp)); // R2
    AST_STAMP_WRAP: assert property (@(posedge uclk) disable iff (rst)
        (run_en && (&stamp)) |=> (stamp == '0)); // R3
endmodule

// File: rtl/ratio_clock_gen.sv
module ratio_clock_gen
    import rcg_pkg::*;
#(
    parameter int unsigned NUM_CLKS = 4,
    parameter int unsigned RATIO_W  = RCG_RATIO_W,
    parameter int unsigned STAMP_W  = RCG_STAMP_W
) (
    input  logic                        uclk,
    input  logic                        rst,
    input  logic                        run_en,
    input  logic [NUM_CLKS*RATIO_W-1:0] div_cfg,
    input  logic [NUM_CLKS*RATIO_W-1:0] phase_cfg,
    input  logic [NUM_CLKS-1:0]         duty_cfg,
    output logic [NUM_CLKS-1:0]         cclk,
    output logic                        fast_strobe,
    output logic [STAMP_W-1:0]          cycle_stamp
);
    typedef struct packed {
        logic fast;
    } top_st_t;

    top_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.fast = run_en && !rst;
    end

    always_ff @(posedge uclk) begin
        st_q <= st_d;
    end

    assign fast_strobe = st_q.fast;

    for (genvar gi = 0; gi < NUM_CLKS; gi++) begin : g_lane
        rcg_lane #(
            .RATIO_W (RATIO_W)
        ) u_lane (
            .uclk      (uclk),
            .rst       (rst),
            .run_en    (run_en),
            .div_n     (div_cfg[gi*RATIO_W +: RATIO_W]),
            .phase_n   (phase_cfg[gi*RATIO_W +: RATIO_W]),
            .duty_mode (duty_cfg[gi]),
            .lane_out  (cclk[gi])
        );
    end

    rcg_stamp #(
        .STAMP_W (STAMP_W)
    ) u_stamp (
        .uclk   (uclk),
        .rst    (rst),
        .run_en (run_en),
        .stamp  (cycle_stamp)
    );

    AST_FAST_ON: assert property (@(posedge uclk) disable iff (rst)
        run_en |=> fast_strobe); // R4
    AST_FAST_OFF: assert property (@(posedge uclk) disable iff (rst)
        !run_en |=> !fast_strobe); // R4
endmodule

// File: tb/ratio_clock_gen_bench.sv
module ratio_clock_gen_bench;
    localparam int NC = 4;
    localparam int RW = 8;
    localparam int SW = 64;
    localparam int NW = 4;

    logic           uclk = 1'b0;
    logic           rst = 1'b1;
    logic           run_en = 1'b0;
    logic [NC*RW-1:0] div_cfg = '0;
    logic [NC*RW-1:0] phase_cfg = '0;
    logic [NC-1:0]  duty_cfg = '0;
    logic [NC-1:0]  cclk, cclk_n;
    logic           fast_strobe, fast_n;
    logic [SW-1:0]  cycle_stamp;
    logic [NW-1:0]  stamp_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int rat [NC];
    int ph [NC];
    bit dd [NC];
    logic exp_prev [NC];
    int k_en;
    logic [SW-1:0] exp_stamp;

    always #10 uclk = ~uclk;

    ratio_clock_gen #(.NUM_CLKS(NC), .RATIO_W(RW), .STAMP_W(SW)) u_ratio_clock_gen (
        .uclk(uclk), .rst(rst), .run_en(run_en), .div_cfg(div_cfg),
        .phase_cfg(phase_cfg), .duty_cfg(duty_cfg), .cclk(cclk),
        .fast_strobe(fast_strobe), .cycle_stamp(cycle_stamp));

    ratio_clock_gen #(.NUM_CLKS(NC), .RATIO_W(RW), .STAMP_W(NW)) u_ratio_clock_gen_w4 (
        .uclk(uclk), .rst(rst), .run_en(run_en), .div_cfg(div_cfg),
        .phase_cfg(phase_cfg), .duty_cfg(duty_cfg), .cclk(cclk_n),
        .fast_strobe(fast_n), .cycle_stamp(stamp_n));

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_lane(int k, int n, int p, bit d, bit en, logic prev);
        int ne;
        int phs;
        ne = (n == 0) ? 1 : n;
        if (d && ne == 1) ne = 2;
        if (!en) return d ? prev : 1'b0;
        if (k < p) return 1'b0;
        phs = (k - p) % ne;
        return d ? (phs < ne / 2) : (phs == 0);
    endfunction

    function automatic string lane_tag(int n, bit d, int k, int p);
        if (k < p) return "R9";
        if (n == 0) return "R10";
        if (!d) return "R5";
        if (n == 1) return "R7";
        return "R6";
    endfunction

    task automatic configure(int r0, int p0, bit d0, int r1, int p1, bit d1,
                             int r2, int p2, bit d2, int r3, int p3, bit d3);
        rat[0] = r0; ph[0] = p0; dd[0] = d0;
        rat[1] = r1; ph[1] = p1; dd[1] = d1;
        rat[2] = r2; ph[2] = p2; dd[2] = d2;
        rat[3] = r3; ph[3] = p3; dd[3] = d3;
        rst = 1'b1;
        run_en = 1'b1;
        for (int i = 0; i < NC; i++) begin
            div_cfg[i*RW +: RW] = RW'(rat[i]);
            phase_cfg[i*RW +: RW] = RW'(ph[i]);
            duty_cfg[i] = dd[i];
        end
        @(posedge uclk); #2;
        @(posedge uclk); #2;
        check("R1 cclk", 64'(cclk), 64'd0);
        check("R1 fast", 64'(fast_strobe), 64'd0);
        check("R1 stamp", cycle_stamp, 64'd0);
        check("R1 stamp_w4", 64'(stamp_n), 64'd0);
        rst = 1'b0;
        k_en = 0;
        exp_stamp = '0;
        for (int i = 0; i < NC; i++) exp_prev[i] = 1'b0;
    endtask

    task automatic step(bit en);
        logic e;
        run_en = en;
        @(posedge uclk); #2;
        for (int i = 0; i < NC; i++) begin
            e = exp_lane(k_en, rat[i], ph[i], dd[i], en, exp_prev[i]);
            if (!en)
                check(dd[i] ? "R8 hold" : "R5 idle", 64'(cclk[i]), 64'(e));
            else
                check(lane_tag(rat[i], dd[i], k_en, ph[i]), 64'(cclk[i]), 64'(e));
            exp_prev[i] = e;
        end
        if (en) begin
            exp_stamp = exp_stamp + 64'd1;
            k_en++;
        end
        check("R2 stamp", cycle_stamp, exp_stamp);
        check("R3 stamp_w4", 64'(stamp_n), 64'(exp_stamp[NW-1:0]));
        check("R4 fast", 64'(fast_strobe), 64'(en));
    endtask

    task automatic run_mix(int cycles);
        for (int c = 0; c < cycles; c++) begin
            if (c >= 40 && c < 52) step(1'b0);
            else if (c < 20) step(1'b1);
            else step(($urandom % 4) != 0);
        end
    endtask

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd20050121);
        // round 1: 1/1 strobe, 4/1 strobe with phase, 5/1 defined duty, 1/1 defined duty
        configure(1, 0, 1'b0, 4, 2, 1'b0, 5, 1, 1'b1, 1, 0, 1'b1);
        run_mix(300);
        // round 2: divisor 0 (R10), defined 3/1, 7/1 strobe with max phase, 2/1 defined
        configure(0, 0, 1'b0, 3, 2, 1'b1, 7, 6, 1'b0, 2, 1, 1'b1);
        run_mix(300);
        // round 3: divisor 0 defined duty, long divisor, stall right after reset
        configure(0, 1, 1'b1, 255, 3, 1'b1, 16, 15, 1'b0, 6, 5, 1'b1);
        step(1'b0); step(1'b0);
        run_mix(700);
        // mid-run reset clears everything (R1)
        configure(2, 0, 1'b0, 2, 0, 1'b1, 9, 4, 1'b1, 1, 0, 1'b0);
        run_mix(200);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule